// File: doc/BRIEF.md
# Octal DAC Serial Command Decoder

This block is the digital front end of an eight-channel voltage-output converter. A host sends 16-bit command words over a three-wire link: a serial clock, a data line and an active-low select that doubles as the load strobe. While the select is low, each rising serial clock edge moves one data bit into a 16-bit shift register. When the select returns high, the word in the register is decoded. Depending on its 4-bit command field, the decoder writes one channel's code register, writes every channel with the same value, changes nothing, or enters a low-power sleep state. While asleep, every stored code is kept.

The last stage of the shift register drives a serial output. Several devices can therefore share one select and one clock, with the output of each device feeding the data input of the next. The code width is a parameter of 8 or 10 bits. Both serial control inputs are sampled in the block's own system clock domain, which must run at least four times faster than the serial clock. An active-low clear input empties the shift register and zeroes all code registers at once, without waiting for a clock.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset, every channel code is zero, the sleep flag is 0 and `dout` is 0.
- R2: A bit is shifted in only on a rising `sck` edge seen while `csLd` is low. Edges on `sck` while `csLd` is high do not move the shift register, so `dout` stays put and a later load acts on the unchanged word.
- R3: Word layout, first bit sent first: command bits [15:12], then a code field of CODE_W bits MSB first at [11:12-CODE_W], then don't-care filler bits. On a rising `csLd`, commands 1 to 8 write the code field into channel 0 to 7 respectively (channel = command − 1). The new value is visible within eight `clk` cycles of the rise.
- R4: Command 15 writes the same code field into all eight channels.
- R5: Command 14 sets the sleep flag and ignores the code field, so every channel keeps its code.
- R6: Commands 0 and 9 to 13 write no channel. Every load whose command is not 14 clears the sleep flag. Channels that a load does not address keep their previous codes.
- R7: `dout` is the oldest bit of the shift register. A bit presented on `din` appears on `dout` after 16 qualifying `sck` rises.
- R8: While `clrN` is low, the shift register, all channel codes and the sleep flag are zero, without waiting for a clock.
- R9: If fewer or more than 16 bits are shifted before `csLd` rises, the load decodes whatever the last 16 shifted bits form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| clrN | input | 1 | Asynchronous active-low clear of the shift register, codes and sleep flag |
| sck | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| csLd | input | 1 | Active-low select; its rising edge loads the word |
| dout | output | 1 | Serial data out, for chaining devices |
| chanCodes | output | 8*CODE_W | Channel codes; channel i is at [i*CODE_W +: CODE_W] |
| sleep | output | 1 | Sleep flag |

## Verification
The bench targets the cases a decoder most easily gets wrong:
- Serial clock pulses sent while the select is high would corrupt the held word if gating were missing. That would turn a later reload of the word into a broadcast of all ones.
- A sleep command with a non-zero code field would overwrite channels if the field were not ignored.
- A no-change command issued during sleep would leave the device asleep if waking were tied only to channel writes.
- Short and long words check that the load decodes the last 16 bits rather than counting edges. The bench also checks that the clear input zeroes the outputs without a clock edge.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 4'hE;
  localparam logic [CMD_W-1:0] CMD_ALL   = 4'hF;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } cmdStrobes_t;
endpackage

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        din,
  input  logic        csLd,
  output logic        dinSync,
  output cmdStrobes_t strobes
);
  // Two synchronizer stages per input, plus one history stage for edge detection.
  logic [2:0] sckPipe;
  logic [2:0] csPipe;
  logic [1:0] dinPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;  // idle-high select: no spurious load edge after reset
      dinPipe <= '0;
    end else begin
      sckPipe <= {sckPipe[1:0], sck};
      csPipe  <= {csPipe[1:0], csLd};
      dinPipe <= {dinPipe[0], din};
    end
  end

  logic sckRise;
  logic csRise;
  assign sckRise = sckPipe[1] & ~sckPipe[2];
  assign csRise  = csPipe[1] & ~csPipe[2];

  always_comb begin
    strobes.shiftEn = sckRise & ~csPipe[1];
    strobes.loadEn  = csRise;
  end

  assign dinSync = dinPipe[1];
endmodule

// File: rtl/dac_cmd_datapath.sv
module dac_cmd_datapath
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rstAllN,
  input  cmdStrobes_t              strobes,
  input  logic                     dinSync,
  output logic                     dout,
  output logic [N_CH*CODE_W-1:0]   chanCodes,
  output logic                     sleep
);
  localparam int CMD_LSB  = WORD_W - CMD_W;
  localparam int CODE_MSB = CMD_LSB - 1;

  logic [WORD_W-1:0] shiftReg;
  logic [CMD_W-1:0]  cmdField;
  logic [CODE_W-1:0] codeField;

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN)             shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dinSync};
  end

  assign cmdField  = shiftReg[WORD_W-1 -: CMD_W];
  assign codeField = shiftReg[CODE_MSB -: CODE_W];
  assign dout      = shiftReg[WORD_W-1];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic chanHit;
    assign chanHit = strobes.loadEn &&
                     ((cmdField == CMD_W'(ch + 1)) || (cmdField == CMD_ALL));
    always_ff @(posedge clk or negedge rstAllN) begin
      if (!rstAllN)     chanCodes[ch*CODE_W +: CODE_W] <= '0;
      else if (chanHit) chanCodes[ch*CODE_W +: CODE_W] <= codeField;
    end
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN)            sleep <= 1'b0;
    else if (strobes.loadEn) sleep <= (cmdField == CMD_SLEEP);
  end
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clrN,
  input  logic                   sck,
  input  logic                   din,
  input  logic                   csLd,
  output logic                   dout,
  output logic [N_CH*CODE_W-1:0] chanCodes,
  output logic                   sleep
);
  localparam int WORD_W = 16;

  cmdStrobes_t strobes;
  logic        dinSync;
  logic        rstAllN;

  assign rstAllN = rstN & clrN;

  dac_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sck     (sck),
    .din     (din),
    .csLd    (csLd),
    .dinSync (dinSync),
    .strobes (strobes)
  );

  dac_cmd_datapath #(
    .CODE_W (CODE_W),
    .N_CH   (N_CH),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk       (clk),
    .rstAllN   (rstAllN),
    .strobes   (strobes),
    .dinSync   (dinSync),
    .dout      (dout),
    .chanCodes (chanCodes),
    .sleep     (sleep)
  );
endmodule

// File: rtl/dac_cmd_checker.sv
module dac_cmd_checker
  import dac_cmd_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   clrN,
  input cmdStrobes_t            strobes,
  input logic                   dout,
  input logic [N_CH*CODE_W-1:0] chanCodes,
  input logic                   sleep
);
  // R3: channel codes move only in the cycle after a load strobe
  p_codes_hold_r3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strobes.loadEn |=> $stable(chanCodes));

  // R2: the serial output moves only after a qualified shift
  p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strobes.shiftEn |=> $stable(dout));

  // R5: entering sleep needs a load
  p_sleep_rise_r5: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    $rose(sleep) |-> $past(strobes.loadEn));

  // R6: leaving sleep needs a load
  p_sleep_fall_r6: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    $fell(sleep) |-> $past(strobes.loadEn));

  // R8: clear holds everything at zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (chanCodes == '0 && !sleep && !dout));
endmodule

bind dac_cmd_decoder dac_cmd_checker #(.CODE_W(CODE_W), .N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clrN      (clrN),
  .strobes   (strobes),
  .dout      (dout),
  .chanCodes (chanCodes),
  .sleep     (sleep)
);

// File: tb/sim_dac_cmd_decoder.sv
module sim_dac_cmd_decoder;
  localparam int CODE_W = 8;
  localparam int N_CH   = 8;

  logic clk = 1'b0, rstN = 1'b0, clrN = 1'b1;
  logic sck = 1'b0, din = 1'b0, csLd = 1'b1;
  logic dout, sleep;
  logic [N_CH*CODE_W-1:0] chanCodes;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dac_cmd_decoder #(.CODE_W(CODE_W), .N_CH(N_CH)) u0 (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sck(sck), .din(din), .csLd(csLd),
    .dout(dout), .chanCodes(chanCodes), .sleep(sleep)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] codeOf(int ch);
    return 32'(chanCodes[ch*CODE_W +: CODE_W]);
  endfunction

  function automatic logic [15:0] mkWord(int cmd, int code);
    return 16'((cmd << 12) | (code << (12 - CODE_W)));
  endfunction

  // ---------------- reference model ----------------
  int mCodes[N_CH];
  logic [15:0] mShift;
  logic mSleep;
  logic hSck[3], hCs[3], hDin[3];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin hSck[i] = 0; hCs[i] = 1; hDin[i] = 0; end
      mShift = 0; mSleep = 0;
      for (int i = 0; i < N_CH; i++) mCodes[i] = 0;
    end else begin
      if (!clrN) begin
        mShift = 0; mSleep = 0;
        for (int i = 0; i < N_CH; i++) mCodes[i] = 0;
      end else begin
        if (hSck[1] && !hSck[2] && !hCs[1]) mShift = {mShift[14:0], hDin[1]};
        if (hCs[1] && !hCs[2]) begin
          int cmd, code;
          cmd  = int'(mShift[15:12]);
          code = int'(mShift[11 -: CODE_W]);
          if (cmd >= 1 && cmd <= N_CH) mCodes[cmd-1] = code;
          else if (cmd == 15) for (int i = 0; i < N_CH; i++) mCodes[i] = code;
          mSleep = (cmd == 14);
        end
      end
      hSck[2] = hSck[1]; hSck[1] = hSck[0]; hSck[0] = sck;
      hCs[2]  = hCs[1];  hCs[1]  = hCs[0];  hCs[0]  = csLd;
      hDin[2] = hDin[1]; hDin[1] = hDin[0]; hDin[0] = din;
    end
  end

  always @(posedge clk) begin
    #3;
    check("R7 model dout", 32'(dout), 32'(mShift[15]));
    check("R5 model sleep", 32'(sleep), 32'(mSleep));
    for (int i = 0; i < N_CH; i++) check("R3 model code", codeOf(i), 32'(mCodes[i]));
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(logic [31:0] val, int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = val[i]; tick(2); sck = 1'b1; tick(2); sck = 1'b0;
    end
  endtask

  task automatic sendWord(logic [31:0] val, int n);
    csLd = 1'b0; tick(2);
    shiftBits(val, n);
    tick(2); csLd = 1'b1; tick(8);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w1, w2, nw;
    tick(5); rstN = 1'b1; tick(3);
    // R1 reset state
    for (int i = 0; i < N_CH; i++) check("R1 code", codeOf(i), 0);
    check("R1 sleep", 32'(sleep), 0);
    check("R1 dout", 32'(dout), 0);

    // R3 single channel writes
    sendWord(mkWord(1, 8'hA5), 16);
    sendWord(mkWord(8, 8'h3C), 16);
    check("R3 chan0", codeOf(0), 32'hA5);
    check("R3 chan7", codeOf(7), 32'h3C);
    check("R3 chan3 untouched", codeOf(3), 0);

    // R4 broadcast
    sendWord(mkWord(15, 8'h5A), 16);
    for (int i = 0; i < N_CH; i++) check("R4 all", codeOf(i), 32'h5A);

    // R6 unwritten channels keep codes
    sendWord(mkWord(3, 8'h11), 16);
    check("R6 chan2 written", codeOf(2), 32'h11);
    check("R6 chan1 kept", codeOf(1), 32'h5A);

    // R5 sleep ignores code field
    sendWord(mkWord(14, 8'hFF), 16);
    check("R5 sleep set", 32'(sleep), 1);
    check("R5 chan0 kept", codeOf(0), 32'h5A);
    check("R5 chan2 kept", codeOf(2), 32'h11);

    // R6 no-change command wakes, writes nothing
    sendWord(mkWord(9, 8'h77), 16);
    check("R6 wake on cmd9", 32'(sleep), 0);
    check("R6 chan0 unchanged", codeOf(0), 32'h5A);
    sendWord(mkWord(14, 8'h00), 16);
    sendWord(mkWord(0, 8'h66), 16);
    check("R6 wake on cmd0", 32'(sleep), 0);
    check("R6 chan4 unchanged", codeOf(4), 32'h5A);

    // R2 shift gated while select high
    sendWord(mkWord(2, 8'h42), 16);
    din = 1'b1;
    for (int i = 0; i < 16; i++) begin tick(2); sck = 1'b1; tick(2); sck = 1'b0; end
    tick(4);
    check("R2 dout held", 32'(dout), 0);
    csLd = 1'b0; tick(4); csLd = 1'b1; tick(8);
    check("R2 chan1 reload", codeOf(1), 32'h42);
    check("R2 chan0 not broadcast", codeOf(0), 32'h5A);

    // R7 serial pass-through delay
    w1 = mkWord(4, 8'h81);
    w2 = mkWord(5, 8'h37);
    csLd = 1'b0; tick(2);
    shiftBits(32'(w1), 16); tick(3);
    check("R7 dout first", 32'(dout), 32'(w1[15]));
    shiftBits(32'(w2 >> 15), 1); tick(3);
    check("R7 dout second", 32'(dout), 32'(w1[14]));
    shiftBits(32'(w2), 15);
    tick(2); csLd = 1'b1; tick(8);
    check("R7 chan4 loaded", codeOf(4), 32'h37);
    check("R7 chan3 not loaded", codeOf(3), 32'h5A);

    // R9 short word: last 16 bits decide
    nw = {w2[7:0], 8'h3A};
    sendWord(32'h3A, 8);
    check("R9 short word", codeOf(int'(nw[15:12]) - 1), 32'(nw[11 -: CODE_W]));
    // R9 long word
    sendWord({12'h0, 4'hF, mkWord(6, 8'hC7)}, 20);
    check("R9 long word", codeOf(5), 32'hC7);

    // R8 asynchronous clear
    sendWord(mkWord(14, 8'h00), 16);
    csLd = 1'b0; tick(2); shiftBits(32'hFF, 8);
    clrN = 1'b0; #1;
    check("R8 chan5 cleared", codeOf(5), 0);
    check("R8 sleep cleared", 32'(sleep), 0);
    check("R8 dout cleared", 32'(dout), 0);
    tick(3); clrN = 1'b1; tick(2);
    csLd = 1'b1; tick(8);
    check("R8 chan0 after clear", codeOf(0), 0);
    sendWord(mkWord(1, 8'h99), 16);
    check("R8 write after clear", codeOf(0), 32'h99);

    tick(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule